// File: doc/BRIEF.md
# Predictive Overcurrent Limiter

This block sits between the output-current ADC and the PWM stage of an inverter leg. Each accepted current sample first passes a spike filter. The filter compares the sample with the median of itself and the two raw samples before it. A sample that lies too far from that median is treated as an isolated glitch, and the median is used in its place.

The filtered value is converted to a magnitude, so that both half-cycles of the AC current are handled the same way. The block then checks the magnitude and its sample-to-sample rise against programmable thresholds. If a fast rise toward the limit is seen on two samples in a row, it raises a limit request before the current reaches the hard limit. The request is released only after the current has stayed low for a programmed number of samples.

A separate fast path takes the gate-driver desaturation fault. This path latches a shutdown output that only an explicit clear can remove.

Top module: `ocp_predictor`

## Requirements
- R1: While rst_ni is low, filt_vld_o, filt_o, limit_req_o and shutdown_o are all zero. The raw-sample history and the previous filtered magnitude also reset to zero.
- R2: filt_vld_o is high for exactly the one cycle after each clock edge at which sample_vld_i was high, and low otherwise.
- R3: Let m be the median of the new sample and the two raw samples accepted before it. If the new sample differs from m by no more than spike_thr_i, filt_o equals the new sample.
- R4: If the new sample differs from m by more than spike_thr_i, filt_o equals m. The history always stores raw samples, never the substituted values. This applies in both polarities.
- R5: Samples are signed 12-bit two's complement. All level and slope decisions use the absolute value of the filtered sample, so negative currents trip exactly as positive ones do.
- R6: The slope is the filtered magnitude minus the previous filtered magnitude. A sample qualifies when its magnitude > warn_lvl_i and its slope > slope_thr_i. limit_req_o sets on the second qualifying sample in a row; a single qualifying sample does not set it.
- R7: limit_req_o changes only at the clock edge that follows a cycle with filt_vld_o high. It therefore trails the input sample by two edges.
- R8: While limit_req_o is set, it clears after release_cnt_i consecutive filtered samples with magnitude < release_lvl_i. A sample at or above that level restarts the count, and cycles without a sample leave the count unchanged.
- R9: shutdown_o is high after the first clock edge at which hw_fault_i is high, independent of the sample stream.
- R10: shutdown_o stays high until an edge with fault_clr_i high and hw_fault_i low. When both are high, the fault wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | Sample strobe |
| sample_i | input | 12 | Signed current sample |
| spike_thr_i | input | 12 | Outlier threshold against the median |
| warn_lvl_i | input | 12 | Magnitude warning level |
| slope_thr_i | input | 12 | Rising-slope threshold |
| release_lvl_i | input | 12 | Magnitude below which release counting runs |
| release_cnt_i | input | 8 | Low samples required to release |
| hw_fault_i | input | 1 | Hardware desaturation fault |
| fault_clr_i | input | 1 | Explicit shutdown clear |
| filt_vld_o | output | 1 | Filtered sample strobe |
| filt_o | output | 12 | Filtered signed sample |
| limit_req_o | output | 1 | Current-limit request to the PWM stage |
| shutdown_o | output | 1 | Latched hardware shutdown |

## Verification
The filtered sample and its strobe are due one edge after the sample strobe. The limit request is due one edge after that, and the shutdown latch is due one edge after the fault input. Inputs are driven on the falling edge. Each sample is held for one rising edge and followed by one idle edge. The bench reads filt_o, filt_vld_o and the still-unchanged limit_req_o at the falling edge after the first rising edge, and reads the updated limit_req_o one falling edge later. Shutdown and clear are checked at the falling edge right after the edge that acts on them.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int unsigned OCP_SAMPLE_W = 12;
  localparam int unsigned OCP_CNT_W    = 8;
endpackage

// File: rtl/ocp_spike_filter.sv
module ocp_spike_filter #(
  parameter int unsigned W = ocp_pkg::OCP_SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic signed [W-1:0] x_i,
  input  logic        [W-1:0] thr_i,
  output logic                vld_o,
  output logic signed [W-1:0] y_o
);
  logic signed [W-1:0] h1_q, h2_q, med;
  logic signed [W:0]   diff;
  logic        [W:0]   adiff;
  logic                spike;

  always_comb begin
    if ((x_i >= h1_q && x_i <= h2_q) || (x_i <= h1_q && x_i >= h2_q))
      med = x_i;
    else if ((h1_q >= x_i && h1_q <= h2_q) || (h1_q <= x_i && h1_q >= h2_q))
      med = h1_q;
    else
      med = h2_q;
    diff  = $signed({x_i[W-1], x_i}) - $signed({med[W-1], med});
    adiff = diff[W] ? (-diff) : diff;
    spike = adiff > {1'b0, thr_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h1_q  <= '0;
      h2_q  <= '0;
      vld_o <= 1'b0;
      y_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        h2_q <= h1_q;
        h1_q <= x_i;  // history keeps raw samples
        y_o  <= spike ? med : x_i;
      end
    end
  end
endmodule

// File: rtl/ocp_trend_detect.sv
module ocp_trend_detect #(
  parameter int unsigned W     = ocp_pkg::OCP_SAMPLE_W,
  parameter int unsigned CNT_W = ocp_pkg::OCP_CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic signed [W-1:0] y_i,
  input  logic        [W-1:0] warn_i,
  input  logic        [W-1:0] slope_thr_i,
  input  logic        [W-1:0] rel_lvl_i,
  input  logic    [CNT_W-1:0] rel_cnt_i,
  output logic                req_o
);
  logic        [W-1:0]   mag, pm_q;
  logic signed [W:0]     slope;
  logic                  qual, qual_q, fire, below, rel_done;
  logic    [CNT_W-1:0]   rel_q;

  always_comb begin
    mag      = y_i[W-1] ? W'(-y_i) : y_i;
    slope    = $signed({1'b0, mag}) - $signed({1'b0, pm_q});
    qual     = (mag > warn_i) && (slope > $signed({1'b0, slope_thr_i}));
    fire     = qual && qual_q;
    below    = mag < rel_lvl_i;
    rel_done = ({1'b0, rel_q} + 1'b1) >= {1'b0, rel_cnt_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pm_q   <= '0;
      qual_q <= 1'b0;
      rel_q  <= '0;
      req_o  <= 1'b0;
    end else if (vld_i) begin
      pm_q   <= mag;
      qual_q <= qual;
      if (fire) begin
        req_o <= 1'b1;
        rel_q <= '0;
      end else if (req_o && below) begin
        if (rel_done) begin
          req_o <= 1'b0;
          rel_q <= '0;
        end else begin
          rel_q <= rel_q + 1'b1;
        end
      end else begin
        rel_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic clr_i,
  output logic shut_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shut_o <= 1'b0;
    else if (fault_i) shut_o <= 1'b1;
    else if (clr_i)   shut_o <= 1'b0;
  end
endmodule

// File: rtl/ocp_predictor.sv
module ocp_predictor #(
  parameter int unsigned W     = ocp_pkg::OCP_SAMPLE_W,
  parameter int unsigned CNT_W = ocp_pkg::OCP_CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_vld_i,
  input  logic signed [W-1:0] sample_i,
  input  logic        [W-1:0] spike_thr_i,
  input  logic        [W-1:0] warn_lvl_i,
  input  logic        [W-1:0] slope_thr_i,
  input  logic        [W-1:0] release_lvl_i,
  input  logic    [CNT_W-1:0] release_cnt_i,
  input  logic                hw_fault_i,
  input  logic                fault_clr_i,
  output logic                filt_vld_o,
  output logic signed [W-1:0] filt_o,
  output logic                limit_req_o,
  output logic                shutdown_o
);
  ocp_spike_filter #(.W(W)) u_filt (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .vld_i (sample_vld_i), .x_i(sample_i), .thr_i(spike_thr_i),
    .vld_o (filt_vld_o), .y_o(filt_o)
  );

  ocp_trend_detect #(.W(W), .CNT_W(CNT_W)) u_trend (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .vld_i (filt_vld_o), .y_i(filt_o),
    .warn_i(warn_lvl_i), .slope_thr_i(slope_thr_i),
    .rel_lvl_i(release_lvl_i), .rel_cnt_i(release_cnt_i),
    .req_o (limit_req_o)
  );

  ocp_fault_latch u_fault (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fault_i(hw_fault_i), .clr_i(fault_clr_i),
    .shut_o(shutdown_o)
  );
endmodule

// File: rtl/ocp_predictor_chk.sv
module ocp_predictor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sample_vld_i,
  input logic hw_fault_i,
  input logic fault_clr_i,
  input logic filt_vld_o,
  input logic limit_req_o,
  input logic shutdown_o
);
  assert_filt_vld_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_i |=> filt_vld_o);
  assert_filt_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> !filt_vld_o);
  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !filt_vld_o |=> $stable(limit_req_o));
  assert_shut_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_fault_i |=> shutdown_o);
  assert_shut_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && !fault_clr_i) |=> shutdown_o);
  assert_shut_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_clr_i && !hw_fault_i) |=> !shutdown_o);
endmodule

bind ocp_predictor ocp_predictor_chk u_chk (.*);

// File: tb/ocp_predictor_bench.sv
`timescale 1ns/1ps
module ocp_predictor_bench;
  localparam int N = 26;
  localparam int VX[N] = '{100, 200, 1500, 300, 500, 700, 900, 1100, 1300, 1250,
                           1000, 800, 600, 400, 300, 600, 400, 350, 200, -100,
                           -400, -700, -1000, -1200, -1400, 900};
  localparam int VF[N] = '{100, 200, 200, 300, 500, 700, 900, 1100, 1300, 1250,
                           1000, 800, 600, 400, 300, 600, 400, 350, 200, -100,
                           -400, -700, -1000, -1200, -1400, -1200};
  localparam int VR[N] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1,
                           0, 0, 0, 0, 0, 0, 1, 1};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sample_vld_i = 1'b0, hw_fault_i = 1'b0, fault_clr_i = 1'b0;
  logic signed [11:0] sample_i = '0;
  logic [11:0] spike_thr_i = 12'd300, warn_lvl_i = 12'd1000;
  logic [11:0] slope_thr_i = 12'd100, release_lvl_i = 12'd500;
  logic [7:0]  release_cnt_i = 8'd3;
  logic filt_vld_o, limit_req_o, shutdown_o;
  logic signed [11:0] filt_o;
  int checks = 0, failures = 0;

  always #4 clk_i = ~clk_i;

  ocp_predictor u_ocp_predictor (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int x, input int ef, input int er, input int pr, input string tag);
    @(negedge clk_i);
    sample_vld_i = 1'b1;
    sample_i = 12'(x);
    @(negedge clk_i);
    sample_vld_i = 1'b0;
    chk(filt_vld_o, {"R2 ", tag}, int'(filt_vld_o), 1);
    chk(int'(filt_o) == ef, {"R3/R4/R5 filt ", tag}, int'(filt_o), ef);
    chk(int'(limit_req_o) == pr, {"R7 req not yet updated ", tag}, int'(limit_req_o), pr);
    @(negedge clk_i);
    chk(!filt_vld_o, {"R2 strobe drop ", tag}, int'(filt_vld_o), 0);
    chk(int'(limit_req_o) == er, {"R6/R8 req ", tag}, int'(limit_req_o), er);
    chk(!shutdown_o, {"R9 no fault ", tag}, int'(shutdown_o), 0);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20;
    chk(!filt_vld_o && filt_o == 0 && !limit_req_o && !shutdown_o, "R1 reset",
        int'({filt_vld_o, limit_req_o, shutdown_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!filt_vld_o && !limit_req_o, "R1 idle after reset",
        int'({filt_vld_o, limit_req_o}), 0);

    // vector table: spike, ramp, trip, release, negative half-cycle
    for (int i = 0; i < N; i++)
      put(VX[i], VF[i], VR[i], (i == 0) ? 0 : VR[i-1], $sformatf("vec%0d", i));

    // R9: fault latches on first edge
    @(negedge clk_i);
    hw_fault_i = 1'b1;
    @(negedge clk_i);
    hw_fault_i = 1'b0;
    chk(shutdown_o, "R9 fault latch", int'(shutdown_o), 1);
    chk(limit_req_o, "R9 req path independent", int'(limit_req_o), 1);
    repeat (3) @(negedge clk_i);
    chk(shutdown_o, "R10 hold without clear", int'(shutdown_o), 1);
    // R10: clear while fault held has no effect
    hw_fault_i = 1'b1;
    fault_clr_i = 1'b1;
    @(negedge clk_i);
    hw_fault_i = 1'b0;
    fault_clr_i = 1'b0;
    chk(shutdown_o, "R10 fault beats clear", int'(shutdown_o), 1);
    fault_clr_i = 1'b1;
    @(negedge clk_i);
    fault_clr_i = 1'b0;
    chk(!shutdown_o, "R10 explicit clear", int'(shutdown_o), 0);

    // R1: mid-run reset
    rst_ni = 1'b0;
    #1;
    chk(!limit_req_o && filt_o == 0, "R1 async reset", int'(limit_req_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // history cleared: a lone spike versus zeros is replaced by 0 (R4)
    put(800, 0, 0, 0, "R4 lone spike after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule